// File: doc/BRIEF.md
# Per-Channel White Balance Lookup

This block sits in a display pixel path and corrects colour balance. The red, green and blue subpixels each pass through a separate 256-entry table of 8-bit values. The table value for a subpixel replaces the incoming value. All three subpixels, together with data-enable and both syncs, leave the block exactly one clock later.

A small write-only register bus programs the block.

- **Configuration space.** This space holds one control byte. It sets the page, the correction enable and the reload permission.
- **Table window.** This window covers 256 entries. Each write lands in the table that the page selects.

After reset the three tables must be filled completely, red first, then green, then blue. Until that has happened the pixels pass through unchanged. Once the tables are loaded, further table writes are dropped unless reload is permitted. Permitted reload writes collect in a shadow copy, which replaces the live tables in one step at a frame-boundary strobe.

The pixel port also carries a narrow 6-bit pixel format. In that format every fourth table entry is used, and the result is cut to its upper six bits.

Top module: `wb_lut_corrector`

## Requirements
- R1: Reset clears the control byte, so the page is 00 and enable and reload are both 0. A bus write with `bus_addr[8]`=0 and `bus_addr[7:0]`=0x2A loads the control byte. Within that byte, bits 7:6 are the page, bit 5 is the correction enable, bit 4 is the reload permission, and bits 3:0 are reserved and discarded.
- R2: A bus write with `bus_addr[8]`=1 writes table entry `bus_addr[7:0]` with `bus_wdata`. The target follows the page: 01 selects red, 10 selects green and 11 selects blue. With page 00, such writes change nothing.
- R3: Each table corrects only its own colour. The red table drives `out_r`, the green table drives `out_g` and the blue table drives `out_b`.
- R4: The tables count as loaded only after red entries 0..255, then green entries 0..255, then blue entries 0..255 have been written in exactly that order. Any table write that breaks the order restarts tracking at red entry 0. A red entry-0 write that breaks the order counts as the first step of the new attempt.
- R5: While the enable bit is 0, or while the tables are not loaded, each output equals its input.
- R6: After loading, table writes made with reload permission 0 are discarded.
- R7: After loading, table writes made with reload permission 1 may touch any subset of entries and tables. They become visible only together, at the clock edge where `frame_strobe` is 1. Pixels before that edge see only the old values.
- R8: With `mode_6b`=1, the lookup index is the input's low 6 bits followed by two zero bits. The output is the entry's upper 6 bits in bits 5:0, with bits 7:6 set to 0. In bypass, the output is the input's low 6 bits, again with bits 7:6 set to 0.
- R9: Every output is registered. It reflects the inputs of the previous clock edge, and `out_de`, `out_hs` and `out_vs` are delayed by the same single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel and bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for one bus cycle |
| bus_addr | input | 9 | Bit 8 selects the table window (1) or configuration space (0) |
| bus_wdata | input | 8 | Write data |
| frame_strobe | input | 1 | Frame boundary; commits pending reload writes |
| mode_6b | input | 1 | Selects the narrow 6-bit pixel format |
| pix_r | input | 8 | Red subpixel in |
| pix_g | input | 8 | Green subpixel in |
| pix_b | input | 8 | Blue subpixel in |
| pix_de | input | 1 | Data enable in |
| pix_hs | input | 1 | Horizontal sync in |
| pix_vs | input | 1 | Vertical sync in |
| out_r | output | 8 | Corrected red |
| out_g | output | 8 | Corrected green |
| out_b | output | 8 | Corrected blue |
| out_de | output | 1 | Delayed data enable |
| out_hs | output | 1 | Delayed horizontal sync |
| out_vs | output | 1 | Delayed vertical sync |

## Verification
The hardest state to reach is the loaded state. It needs 768 table writes in a strict order, and a single misplaced write silently sends the tracker back to the start. To exercise the restart, the stimulus first runs a load that skips one green entry but still finishes all of blue. Pixels must then still bypass. A clean full load follows.

The second hard case is the seamless reload. The stimulus mixes partial writes to two tables and sweeps pixels before the frame strobe, then again after it. This shows that the old values stay live until the strobe and that every change appears at once.

// File: rtl/wbl_pkg.sv
package wbl_pkg;
   typedef enum logic [1:0] {
      PG_CFG = 2'b00,
      PG_RED = 2'b01,
      PG_GRN = 2'b10,
      PG_BLU = 2'b11
   } page_e;

   localparam int NUM_CH = 3;

   function automatic logic [1:0] page_to_ch(page_e pg);
      return 2'(pg) - 2'd1;
   endfunction
endpackage

// File: rtl/wbl_ctrl.sv
module wbl_ctrl
   import wbl_pkg::*;
#(
   parameter int IDX_W     = 8,
   parameter int ADDR_W    = IDX_W + 1,
   parameter int CTRL_ADDR = 'h2A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic              ctl_en,
   output logic              ctl_reload,
   output logic              loaded,
   output logic [NUM_CH-1:0] wr_act,
   output logic [NUM_CH-1:0] wr_shd,
   output logic [IDX_W-1:0]  wr_idx
);
   localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

   if (ADDR_W != IDX_W + 1) begin : g_bad_addr
      $error("wbl_ctrl: ADDR_W must be IDX_W+1");
   end

   page_e            page_q;
   logic             en_q, rel_q, loaded_q;
   logic [1:0]       exp_ch_q;
   logic [IDX_W-1:0] exp_idx_q;
   logic             cfg_we, win_we, hit;
   logic [1:0]       wr_ch;

   assign wr_idx = bus_addr[IDX_W-1:0];
   assign cfg_we = bus_we && !bus_addr[ADDR_W-1] && (wr_idx == IDX_W'(CTRL_ADDR));
   assign win_we = bus_we && bus_addr[ADDR_W-1] && (page_q != PG_CFG);
   assign wr_ch  = page_to_ch(page_q);
   assign hit    = (wr_ch == exp_ch_q) && (wr_idx == exp_idx_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page_q    <= PG_CFG;
         en_q      <= 1'b0;
         rel_q     <= 1'b0;
         loaded_q  <= 1'b0;
         exp_ch_q  <= 2'd0;
         exp_idx_q <= '0;
      end else begin
         if (cfg_we) begin
            page_q <= page_e'(bus_wdata[7:6]);
            en_q   <= bus_wdata[5];
            rel_q  <= bus_wdata[4];
         end
         if (win_we && !loaded_q) begin
            if (hit) begin
               if (exp_idx_q == LAST_IDX) begin
                  exp_idx_q <= '0;
                  if (exp_ch_q == 2'(NUM_CH - 1)) loaded_q <= 1'b1;
                  else                            exp_ch_q <= exp_ch_q + 2'd1;
               end else begin
                  exp_idx_q <= exp_idx_q + 1'b1;
               end
            end else begin
               exp_ch_q  <= 2'd0;
               exp_idx_q <= (wr_ch == 2'd0 && wr_idx == '0) ? IDX_W'(1) : '0;
            end
         end
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_wr
      assign wr_act[c] = win_we && !loaded_q && (wr_ch == 2'(c));
      assign wr_shd[c] = win_we && loaded_q && rel_q && (wr_ch == 2'(c));
   end

   assign ctl_en     = en_q;
   assign ctl_reload = rel_q;
   assign loaded     = loaded_q;

   AST_LOADED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      loaded_q |=> loaded_q);                                              // R4
   AST_LOAD_ENDS_BLUE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(loaded_q) |-> $past(win_we && page_q == PG_BLU && wr_idx == LAST_IDX)); // R4
   AST_LOCKED_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (loaded_q && !rel_q) |-> (wr_act == '0 && wr_shd == '0));            // R6
endmodule

// File: rtl/wbl_lut_chan.sv
module wbl_lut_chan #(
   parameter int IDX_W = 8,
   parameter int DAT_W = 8
) (
   input  logic             clk,
   input  logic             wr_active,
   input  logic             wr_shadow,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [DAT_W-1:0] wr_data,
   input  logic             commit,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [DAT_W-1:0] rd_data
);
   localparam int DEPTH = 1 << IDX_W;

   logic [DAT_W-1:0] active_q [DEPTH];
   logic [DAT_W-1:0] shadow_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_active || wr_shadow) shadow_q[wr_idx] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (commit)         active_q <= shadow_q;
      else if (wr_active) active_q[wr_idx] <= wr_data;
   end

   assign rd_data = active_q[rd_idx];

   AST_WR_EXCLUSIVE: assert property (@(posedge clk)
      !(wr_active && wr_shadow));                                          // R7
endmodule

// File: rtl/wb_lut_corrector.sv
module wb_lut_corrector
   import wbl_pkg::*;
#(
   parameter int PIX_W     = 8,
   parameter int NARROW_W  = 6,
   parameter int ADDR_W    = PIX_W + 1,
   parameter int CTRL_ADDR = 'h2A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   input  logic              frame_strobe,
   input  logic              mode_6b,
   input  logic [PIX_W-1:0]  pix_r,
   input  logic [PIX_W-1:0]  pix_g,
   input  logic [PIX_W-1:0]  pix_b,
   input  logic              pix_de,
   input  logic              pix_hs,
   input  logic              pix_vs,
   output logic [PIX_W-1:0]  out_r,
   output logic [PIX_W-1:0]  out_g,
   output logic [PIX_W-1:0]  out_b,
   output logic              out_de,
   output logic              out_hs,
   output logic              out_vs
);
   localparam int PAD_W = PIX_W - NARROW_W;

   if (PIX_W != 8) begin : g_bad_pix
      $error("wb_lut_corrector: PIX_W must match the 8-bit bus data");
   end
   if (NARROW_W < 1 || NARROW_W >= PIX_W) begin : g_bad_narrow
      $error("wb_lut_corrector: NARROW_W must lie in 1..PIX_W-1");
   end

   logic              ctl_en, ctl_reload, loaded, use_lut;
   logic [NUM_CH-1:0] wr_act, wr_shd;
   logic [PIX_W-1:0]  wr_idx;
   logic [PIX_W-1:0]  pin  [NUM_CH];
   logic [PIX_W-1:0]  pout [NUM_CH];

   wbl_ctrl #(.IDX_W(PIX_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .ctl_en(ctl_en), .ctl_reload(ctl_reload),
      .loaded(loaded), .wr_act(wr_act), .wr_shd(wr_shd), .wr_idx(wr_idx)
   );

   assign pin[0] = pix_r;
   assign pin[1] = pix_g;
   assign pin[2] = pix_b;
   assign use_lut = ctl_en && loaded;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [PIX_W-1:0] idx, lut_val, nxt;
      assign idx = mode_6b ? {pin[c][NARROW_W-1:0], {PAD_W{1'b0}}} : pin[c];

      wbl_lut_chan #(.IDX_W(PIX_W), .DAT_W(PIX_W)) lut_i (
         .clk(clk), .wr_active(wr_act[c]), .wr_shadow(wr_shd[c]),
         .wr_idx(wr_idx), .wr_data(bus_wdata), .commit(frame_strobe),
         .rd_idx(idx), .rd_data(lut_val)
      );

      always_comb begin
         if (mode_6b)
            nxt = use_lut ? {{PAD_W{1'b0}}, lut_val[PIX_W-1:PAD_W]}
                          : {{PAD_W{1'b0}}, pin[c][NARROW_W-1:0]};
         else
            nxt = use_lut ? lut_val : pin[c];
      end

      always_ff @(posedge clk) begin
         if (!rst_n) pout[c] <= '0;
         else        pout[c] <= nxt;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_de <= 1'b0;
         out_hs <= 1'b0;
         out_vs <= 1'b0;
      end else begin
         out_de <= pix_de;
         out_hs <= pix_hs;
         out_vs <= pix_vs;
      end
   end

   assign out_r = pout[0];
   assign out_g = pout[1];
   assign out_b = pout[2];

   AST_DE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      pix_de |=> out_de);                                                  // R9
   AST_VS_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_vs |=> !out_vs);                                                // R9
   AST_BYPASS_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (!loaded && !mode_6b) |=> (out_r == $past(pix_r) && out_b == $past(pix_b))); // R5
   AST_NARROW_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      mode_6b |=> (out_r[PIX_W-1:NARROW_W] == '0 && out_g[PIX_W-1:NARROW_W] == '0)); // R8
endmodule

// File: tb/wb_lut_corrector_tb_top.sv
module wb_lut_corrector_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_we = 1'b0;
   logic [8:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic       frame_strobe = 1'b0;
   logic       mode_6b = 1'b0;
   logic [7:0] pix_r = '0, pix_g = '0, pix_b = '0;
   logic       pix_de = 1'b0, pix_hs = 1'b0, pix_vs = 1'b0;
   logic [7:0] out_r, out_g, out_b;
   logic       out_de, out_hs, out_vs;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   logic [7:0] m_act [3][256];
   logic [7:0] m_shd [3][256];
   bit m_en = 0, m_rel = 0, m_loaded = 0;
   logic [1:0] m_page = 2'b00;

   always #5 clk = ~clk;

   wb_lut_corrector dut_i (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .frame_strobe(frame_strobe), .mode_6b(mode_6b),
      .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b), .pix_de(pix_de),
      .pix_hs(pix_hs), .pix_vs(pix_vs), .out_r(out_r), .out_g(out_g),
      .out_b(out_b), .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs)
   );

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] expect_px(int c, logic [7:0] v, bit m6);
      logic [7:0] idx;
      idx = m6 ? {v[5:0], 2'b00} : v;
      if (m_en && m_loaded) return m6 ? {2'b00, m_act[c][idx][7:2]} : m_act[c][idx];
      return m6 ? {2'b00, v[5:0]} : v;
   endfunction

   task automatic wr(logic [8:0] a, logic [7:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
      if (!a[8] && a[7:0] == 8'h2A) begin
         m_page = d[7:6]; m_en = d[5]; m_rel = d[4];
      end else if (a[8] && m_page != 2'b00) begin
         if (!m_loaded) begin
            m_act[m_page-1][a[7:0]] = d; m_shd[m_page-1][a[7:0]] = d;
         end else if (m_rel) begin
            m_shd[m_page-1][a[7:0]] = d;
         end
      end
   endtask

   task automatic ctl(logic [1:0] pg, bit en, bit rel);
      wr(9'h02A, {pg, en, rel, 4'hF});
   endtask

   task automatic strobe();
      @(negedge clk);
      frame_strobe = 1'b1;
      @(negedge clk);
      frame_strobe = 1'b0;
      for (int c = 0; c < 3; c++)
         for (int i = 0; i < 256; i++) m_act[c][i] = m_shd[c][i];
   endtask

   task automatic px(string req, logic [7:0] r, logic [7:0] g, logic [7:0] b);
      @(negedge clk);
      pix_r = r; pix_g = g; pix_b = b;
      @(negedge clk);
      chk(req, out_r, expect_px(0, r, mode_6b));
      chk(req, out_g, expect_px(1, g, mode_6b));
      chk(req, out_b, expect_px(2, b, mode_6b));
   endtask

   task automatic sweep(string req, bit m6);
      mode_6b = m6;
      for (int v = 0; v < (m6 ? 64 : 256); v++)
         px(req, 8'(v), 8'(v * 3 + 1), 8'(255 - v));
      mode_6b = 1'b0;
   endtask

   function automatic logic [7:0] f_init(int c, int i);
      return c == 0 ? 8'(i * 7 + 3) : c == 1 ? 8'(255 - i) : 8'(i ^ 8'h5A);
   endfunction

   task automatic load_tab(int c, int skip);
      ctl(2'(c + 1), 1'b1, 1'b0);
      for (int i = 0; i < 256; i++)
         if (i != skip) wr({1'b1, 8'(i)}, f_init(c, i));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < 3; c++)
         for (int i = 0; i < 256; i++) begin m_act[c][i] = 'x; m_shd[c][i] = 'x; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state, outputs and syncs cleared
      chk("R1 reset", out_r, 8'h00);
      chk("R1 reset de", {7'd0, out_de}, 8'd0);

      // R9: sync/de delayed by one cycle
      @(negedge clk); pix_de = 1; pix_hs = 1; pix_vs = 0;
      @(negedge clk); chk("R9 de", {5'd0, out_de, out_hs, out_vs}, 8'b110);
      pix_de = 0; pix_hs = 0; pix_vs = 1;
      @(negedge clk); chk("R9 vs", {5'd0, out_de, out_hs, out_vs}, 8'b001);
      pix_vs = 0;

      // R5: not loaded -> bypass even with enable
      ctl(2'b00, 1'b1, 1'b0);
      px("R5 bypass unloaded", 8'h12, 8'h34, 8'h56);

      // R4: load with one skipped green entry -> restart, still bypass
      load_tab(0, -1); load_tab(1, 100); load_tab(2, -1);
      sweep("R4 broken order bypass", 1'b0);

      // R2: page 00 window writes ignored (entry set later by full load anyway)
      ctl(2'b00, 1'b1, 1'b0);
      wr(9'h105, 8'hEE);

      // R4: clean load; just before the last blue entry it is still bypass
      load_tab(0, -1); load_tab(1, -1);
      ctl(2'b11, 1'b1, 1'b0);
      for (int i = 0; i < 255; i++) wr({1'b1, 8'(i)}, f_init(2, i));
      px("R4 incomplete bypass", 8'd9, 8'd9, 8'd9);
      wr(9'h1FF, f_init(2, 255));
      m_loaded = 1;
      sweep("R3 R4 loaded lookup", 1'b0);
      sweep("R8 narrow lookup", 1'b1);

      // R5: enable off -> bypass
      ctl(2'b01, 1'b0, 1'b0);
      px("R5 disabled bypass", 8'hA5, 8'h5A, 8'h3C);

      // R6: writes after load without reload are dropped
      ctl(2'b01, 1'b1, 1'b0);
      wr(9'h10A, 8'h00);
      strobe();
      px("R6 locked", 8'h0A, 8'h0A, 8'h0A);

      // R7: partial reload, hidden until strobe
      ctl(2'b01, 1'b1, 1'b1);
      wr(9'h10A, 8'hC3);
      ctl(2'b10, 1'b1, 1'b1);
      wr(9'h114, 8'h77);
      sweep("R7 before strobe", 1'b0);
      strobe();
      px("R7 after strobe", 8'h0A, 8'h14, 8'h0A);
      sweep("R7 committed", 1'b0);

      // R1: reserved bits and a non-0x2A config address have no effect
      wr(9'h02B, 8'h00);
      px("R1 other address", 8'h0A, 8'h14, 8'h01);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule